// File: doc/BRIEF.md
# Flash Command Sequencer with Write Protection

This block is the command front end of a behavioural parallel NOR flash model. It watches the chip-enable, write-enable and output-enable strobes. It takes each completed write cycle on the rising edge of write-enable and steps a multi-cycle unlock sequence. When the sequence is complete, it starts a program or an erase and pulls its active-low ready/busy output to busy. The storage behind it is a small register file. Program and erase times are fixed clock-cycle counts set by parameters.

Writes are refused in three cases: while a supply-lockout input is high, while reset is high, and when they are addressed to a sector group whose protect bit is set. A running erase can be suspended and resumed. An erase that is cut short by reset or lockout leaves its sectors flagged as invalid. A mode input selects 16-bit words or 8-bit bytes. In byte mode, data pin 15 acts as the lowest address bit and only the low eight data pins are driven.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program is the four write cycles (A,0xAA), (B,0x55), (A,0xA0), (target, data). Here A is the unlock address with its even bits set and its odd bits clear, and B is its complement. `ready` goes low one clock after the fourth write-enable rising edge has been sampled, never earlier, and stays low for exactly PROG_CYC clocks.
- R2: An erase is the six cycles (A,0xAA), (B,0x55), (A,0x80), (A,0xAA), (B,0x55), then either (sector address,0x30) for one sector or (A,0x10) for every unprotected sector. `ready` goes low one clock after the sixth rising edge and stays low for ERASE_CYC clocks. The erased words then read 0xFFFF.
- R3: `ready` is low in every clock where `rst` is high. After reset the sequencer is in read mode, and a partly entered command is lost.
- R4: `ready` is high when idle and while an erase is suspended. During an erase, a write of 0xB0 to any address suspends it. While suspended, a write of 0x30 resumes it.
- R5: A write cycle counts only if `ce_n` and `we_n` are low and `oe_n` is high. A cycle with `oe_n` low or `ce_n` high is not seen.
- R6: While `lockout` is high, every write is ignored and the sequencer is forced back to read mode with `ready` high. Any partly entered command is lost.
- R7: `prot` holds one bit per group of SEC_PER_GRP sectors, and the sector is the top bits of the word address. A program or a sector erase aimed at a protected group is dropped, and `ready` stays high. A chip erase skips protected sectors.
- R8: Command cycles decode only `dq_in[7:0]`. The upper eight bits do not matter.
- R9: With `word_mode` low, `dq_in[15]` picks the byte lane (1 = upper) for reads and for the program data cycle. A read returns the byte on `dq_out[7:0]` with `dq_oe` = 0x00FF, and a program changes only the selected lane.
- R10: If an erase is running or suspended when reset or lockout hits, its sectors get their `sector_bad` bit set. A completed erase of a sector clears that bit.
- R11: A cycle that does not match the expected next step drops the sequence back to read mode. A cycle of 0xF0 in the middle of an unlock sequence therefore cancels it.
- R12: A program ANDs the data into the stored word, so it can clear bits but never set them.
- R13: A read cycle (`ce_n` and `oe_n` low, `we_n` high) shows the addressed word on `dq_out` with `dq_oe` = 0xFFFF in word mode, one clock later. Outside a read, `dq_oe` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| lockout | input | 1 | Low-supply lockout, high blocks all writes |
| addr | input | AW | Word address |
| dq_in | input | 16 | Data pins, input side; bit 15 is the byte-lane address in byte mode |
| prot | input | NSEC/SEC_PER_GRP | Protect bit per sector group |
| dq_out | output | 16 | Data pins, output side |
| dq_oe | output | 16 | Per-pin output enable |
| ready | output | 1 | High = ready, low = busy |
| sector_bad | output | NSEC | Sector holds an interrupted erase |

## Verification
The bench uses a 64-word array in four sectors, two sectors to a protect group, a 5-clock program and an 80-clock erase. This lets one group be protected while the other is not, and one run can compare the two. With these sizes an entire chip erase walk takes only 80 clocks, so the bench can measure every busy period to the exact clock. The erase window is long enough to suspend an erase mid-walk, or to cut it short with lockout or reset, and still have time to check the resulting sector flags.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PDATA, S_E1, S_E2, S_E3, S_PROG, S_ERASE, S_SUSP
  } seq_state_t;

  localparam logic [7:0] K_UNLK1  = 8'hAA;
  localparam logic [7:0] K_UNLK2  = 8'h55;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ERSET  = 8'h80;
  localparam logic [7:0] K_CHIP   = 8'h10;
  localparam logic [7:0] K_SECT   = 8'h30;
  localparam logic [7:0] K_SUSP   = 8'hB0;
  localparam logic [7:0] K_RESUME = 8'h30;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port style: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          word_mode,
  input  logic          lockout,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  input  logic [15:0]   rd_word,
  output logic          wr_ev,
  output logic [AW-1:0] ev_addr,
  output logic [15:0]   ev_data,
  output logic          ev_byte,
  output logic          ev_lane,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe
);
  logic wr_act, wr_prev;
  logic rd_on_q, lane_q, byte_q;

  // a write cycle needs both enables low and the output enable high
  assign wr_act = !ce_n && !we_n && oe_n && !lockout;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      wr_ev   <= 1'b0;
      ev_addr <= '0;
      ev_data <= '0;
      ev_byte <= 1'b0;
      ev_lane <= 1'b0;
      rd_on_q <= 1'b0;
      lane_q  <= 1'b0;
      byte_q  <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      wr_ev   <= wr_prev && we_n && !lockout;
      if (wr_prev && we_n) begin
        ev_addr <= addr;
        ev_data <= dq_in;
        ev_byte <= !word_mode;
        ev_lane <= dq_in[15];
      end
      rd_on_q <= !ce_n && !oe_n && we_n;
      lane_q  <= dq_in[15];
      byte_q  <= !word_mode;
    end
  end

  always_comb begin
    dq_out = '0;
    dq_oe  = '0;
    if (rd_on_q) begin
      if (byte_q) begin
        dq_out = {8'h00, (lane_q ? rd_word[15:8] : rd_word[7:0])};
        dq_oe  = 16'h00FF;
      end else begin
        dq_out = rd_word;
        dq_oe  = 16'hFFFF;
      end
    end
  end

  // R5
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ev |-> $past(!ce_n && !we_n && oe_n, 2));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int NSEC        = 8,
  parameter int SEC_PER_GRP = 2,
  parameter int PROG_CYC    = 8,
  parameter int ERASE_CYC   = 400
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        lockout,
  input  logic                        wr_ev,
  input  logic [AW-1:0]               ev_addr,
  input  logic [15:0]                 ev_data,
  input  logic                        ev_byte,
  input  logic                        ev_lane,
  input  logic [NSEC/SEC_PER_GRP-1:0] prot,
  input  logic [AW-1:0]               host_addr,
  input  logic [15:0]                 arr_rdata,
  output logic                        arr_we,
  output logic [AW-1:0]               arr_waddr,
  output logic [15:0]                 arr_wdata,
  output logic [AW-1:0]               arr_raddr,
  output logic                        ready,
  output logic [NSEC-1:0]             sector_bad
);
  localparam int DEPTH = 1 << AW;
  localparam int SB    = $clog2(NSEC);
  localparam int CW    = $clog2(ERASE_CYC + PROG_CYC + DEPTH) + 1;

  function automatic logic [AW-1:0] alt_bits();
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction

  localparam logic [AW-1:0] UA = alt_bits();
  localparam logic [AW-1:0] UB = ~alt_bits();

  function automatic logic [SB-1:0] sec_of(input logic [AW-1:0] a);
    return a[AW-1 -: SB];
  endfunction

  seq_state_t      state, nstate;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   pa;
  logic [15:0]     pdat;
  logic [NSEC-1:0] emask, nmask, sec_prot;
  logic            ld_prog, ld_erase, ready_q;
  logic [7:0]      cmd;
  logic            hit_a, hit_b;

  for (genvar s = 0; s < NSEC; s++) begin : g_prot
    assign sec_prot[s] = prot[s / SEC_PER_GRP];
  end

  assign cmd   = ev_data[7:0];
  assign hit_a = (ev_addr == UA);
  assign hit_b = (ev_addr == UB);

  always_comb begin
    nstate   = state;
    nmask    = emask;
    ld_prog  = 1'b0;
    ld_erase = 1'b0;
    if (lockout) begin
      nstate = S_READ;
    end else if (state == S_PROG) begin
      if (cnt == CW'(PROG_CYC - 1)) nstate = S_READ;
    end else if (state == S_ERASE) begin
      if (cnt == CW'(ERASE_CYC - 1))      nstate = S_READ;
      else if (wr_ev && cmd == K_SUSP)    nstate = S_SUSP;
    end else if (state == S_SUSP) begin
      if (wr_ev && cmd == K_RESUME) nstate = S_ERASE;
    end else if (wr_ev) begin
      nstate = S_READ;
      case (state)
        S_READ:  if (hit_a && cmd == K_UNLK1) nstate = S_U1;
        S_U1:    if (hit_b && cmd == K_UNLK2) nstate = S_U2;
        S_U2: begin
          if (hit_a && cmd == K_PROG)       nstate = S_PDATA;
          else if (hit_a && cmd == K_ERSET) nstate = S_E1;
        end
        S_PDATA: if (!sec_prot[sec_of(ev_addr)]) begin
          nstate  = S_PROG;
          ld_prog = 1'b1;
        end
        S_E1:    if (hit_a && cmd == K_UNLK1) nstate = S_E2;
        S_E2:    if (hit_b && cmd == K_UNLK2) nstate = S_E3;
        S_E3: begin
          if (hit_a && cmd == K_CHIP) begin
            nmask = ~sec_prot;
            if (|nmask) begin
              nstate   = S_ERASE;
              ld_erase = 1'b1;
            end
          end else if (cmd == K_SECT && !sec_prot[sec_of(ev_addr)]) begin
            nmask = '0;
            nmask[sec_of(ev_addr)] = 1'b1;
            nstate   = S_ERASE;
            ld_erase = 1'b1;
          end
        end
        default: nstate = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_READ;
      cnt     <= '0;
      pa      <= '0;
      pdat    <= '1;
      emask   <= '0;
      ready_q <= 1'b0;
    end else begin
      state   <= nstate;
      ready_q <= !(nstate == S_PROG || nstate == S_ERASE);
      if (ld_prog) begin
        cnt <= '0;
        pa  <= ev_addr;
        if (ev_byte) pdat <= ev_lane ? {ev_data[7:0], 8'hFF} : {8'hFF, ev_data[7:0]};
        else         pdat <= ev_data;
      end else if (ld_erase) begin
        cnt   <= '0;
        emask <= nmask;
      end else if ((state == S_PROG || state == S_ERASE) && nstate == state) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // sector health survives reset; it is state of the storage itself
  always_ff @(posedge clk) begin
    if ((rst || lockout) && (state == S_ERASE || state == S_SUSP))
      sector_bad <= sector_bad | emask;
    else if (state == S_ERASE && nstate == S_READ)
      sector_bad <= sector_bad & ~emask;
  end

  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = cnt[AW-1:0];
    arr_wdata = '1;
    if (!rst && !lockout) begin
      if (state == S_PROG && cnt == CW'(1)) begin
        arr_we    = 1'b1;
        arr_waddr = pa;
        arr_wdata = arr_rdata & pdat;
      end else if (state == S_ERASE && cnt < CW'(DEPTH)) begin
        arr_we = emask[sec_of(cnt[AW-1:0])];
      end
    end
  end

  assign arr_raddr = (state == S_PROG) ? pa : host_addr;
  assign ready     = ready_q;

  // R1
  prog_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state == S_PROG) |-> $past(state == S_PDATA && wr_ev));
  // R2
  erase_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state == S_ERASE) |-> $past((state == S_E3 && wr_ev) || state == S_SUSP));
  // R4
  susp_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_SUSP) |-> ready_q);
  // R6
  lockout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    lockout |=> (state == S_READ && ready_q));
  // R7
  prot_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_PROG && arr_we) |-> !sec_prot[sec_of(pa)]);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW          = 8,
  parameter int NSEC        = 8,
  parameter int SEC_PER_GRP = 2,
  parameter int PROG_CYC    = 8,
  parameter int ERASE_CYC   = 400
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ce_n,
  input  logic                        we_n,
  input  logic                        oe_n,
  input  logic                        word_mode,
  input  logic                        lockout,
  input  logic [AW-1:0]               addr,
  input  logic [15:0]                 dq_in,
  input  logic [NSEC/SEC_PER_GRP-1:0] prot,
  output logic [15:0]                 dq_out,
  output logic [15:0]                 dq_oe,
  output logic                        ready,
  output logic [NSEC-1:0]             sector_bad
);
  logic          wr_ev, ev_byte, ev_lane, arr_we;
  logic [AW-1:0] ev_addr, arr_waddr, arr_raddr;
  logic [15:0]   ev_data, arr_wdata, arr_rdata;

  flash_bus_port #(.AW(AW)) i_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .word_mode(word_mode), .lockout(lockout), .addr(addr), .dq_in(dq_in),
    .rd_word(arr_rdata), .wr_ev(wr_ev), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_byte(ev_byte), .ev_lane(ev_lane), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  flash_cmd_fsm #(
    .AW(AW), .NSEC(NSEC), .SEC_PER_GRP(SEC_PER_GRP),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_fsm (
    .clk(clk), .rst(rst), .lockout(lockout), .wr_ev(wr_ev),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_byte(ev_byte), .ev_lane(ev_lane),
    .prot(prot), .host_addr(addr), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_raddr(arr_raddr), .ready(ready), .sector_bad(sector_bad)
  );

  flash_array #(.AW(AW), .DW(16)) i_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );
endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
  localparam int AW = 6, NSEC = 4, SPG = 2, PCYC = 5, ECYC = 80;
  localparam logic [5:0] UA = 6'h15, UB = 6'h2A;

  logic clk = 1'b0, rst = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic word_mode = 1'b1, lockout = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [1:0]  prot = '0;
  logic [15:0] dq_out, dq_oe;
  logic        ready;
  logic [3:0]  sector_bad;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] q_val[$];
  logic [15:0] q_oe[$];
  string       q_tag[$];
  event        mon_ev;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .NSEC(NSEC), .SEC_PER_GRP(SPG),
                  .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) i_flash_cmd_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .word_mode(word_mode), .lockout(lockout), .addr(addr), .dq_in(dq_in),
    .prot(prot), .dq_out(dq_out), .dq_oe(dq_oe), .ready(ready),
    .sector_bad(sector_bad)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read result and compares it with the pins
  always @(mon_ev) begin
    chk(q_tag.pop_front(), {dq_oe, dq_out}, {q_oe.pop_front(), q_val.pop_front()});
  end

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d,
                        input logic ce = 1'b0, input logic oe = 1'b1);
    @(negedge clk); ce_n = ce; we_n = 1'b0; oe_n = oe; addr = a; dq_in = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic lane, input logic [15:0] v,
                        input logic [15:0] oe, input string tag);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; dq_in = {lane, 15'h0};
    q_val.push_back(v); q_oe.push_back(oe); q_tag.push_back(tag);
    @(negedge clk); ->mon_ev;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock(input logic [7:0] hi);
    bus_wr(UA, {hi, 8'hAA});
    bus_wr(UB, {hi, 8'h55});
  endtask

  task automatic erase_seq(input logic [5:0] a, input logic [7:0] code);
    unlock(8'h00);
    bus_wr(UA, 16'h0080);
    unlock(8'h00);
    bus_wr(a, {8'h00, code});
  endtask

  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (!ready && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic idle_chk(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(tag, {31'b0, ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk); chk("R3 busy in reset", {31'b0, ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R3 busy in reset held", {31'b0, ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk); chk("R4 ready idle", {31'b0, ready}, 32'd1);

    // chip erase of everything
    unlock(8'h00); bus_wr(UA, 16'h0080); unlock(8'h00);
    @(negedge clk); chk("R2 ready before 6th", {31'b0, ready}, 32'd1);
    bus_wr(UA, 16'h0010);
    busy_len(n); chk("R2 chip erase busy length", n, ECYC);
    chk("R10 flags clear after erase", {28'b0, sector_bad}, 32'd0);
    rd_exp(6'h07, 1'b0, 16'hFFFF, 16'hFFFF, "R13 erased word read");
    rd_exp(6'h3F, 1'b0, 16'hFFFF, 16'hFFFF, "R2 last word erased");

    // program with junk in the upper byte of command cycles
    unlock(8'hAB); bus_wr(UA, 16'hCDA0);
    @(negedge clk); chk("R1 ready after 3rd", {31'b0, ready}, 32'd1);
    bus_wr(6'h07, 16'h1234);
    busy_len(n); chk("R1 program busy length", n, PCYC);
    rd_exp(6'h07, 1'b0, 16'h1234, 16'hFFFF, "R8 R1 programmed word");

    unlock(8'h00); bus_wr(UA, 16'h00A0); bus_wr(6'h07, 16'hFF0F);
    busy_len(n); chk("R12 second program busy", n, PCYC);
    rd_exp(6'h07, 1'b0, 16'h1204, 16'hFFFF, "R12 AND of data");

    // protection: group 1 holds sectors 2 and 3
    prot = 2'b10;
    unlock(8'h00); bus_wr(UA, 16'h00A0); bus_wr(6'h25, 16'h0000);
    idle_chk("R7 protected program no busy");
    rd_exp(6'h25, 1'b0, 16'hFFFF, 16'hFFFF, "R7 protected word kept");
    erase_seq(6'h30, 8'h30);
    idle_chk("R7 protected erase no busy");
    erase_seq(6'h00, 8'h30);
    busy_len(n); chk("R2 sector erase busy length", n, ECYC);
    rd_exp(6'h07, 1'b0, 16'hFFFF, 16'hFFFF, "R2 sector 0 erased");
    prot = 2'b00;

    // strobe qualification
    bus_wr(UA, 16'h00AA, 1'b0, 1'b0); bus_wr(UB, 16'h0055); bus_wr(UA, 16'h00A0);
    bus_wr(6'h08, 16'h0000);
    idle_chk("R5 oe low breaks write");
    rd_exp(6'h08, 1'b0, 16'hFFFF, 16'hFFFF, "R5 oe low word kept");
    bus_wr(UA, 16'h00AA, 1'b1, 1'b1); bus_wr(UB, 16'h0055); bus_wr(UA, 16'h00A0);
    bus_wr(6'h08, 16'h0000);
    idle_chk("R5 ce high breaks write");
    rd_exp(6'h08, 1'b0, 16'hFFFF, 16'hFFFF, "R5 ce high word kept");

    // sequence aborts
    bus_wr(UA, 16'h00AA); bus_wr(UB, 16'h0056); bus_wr(UA, 16'h00A0); bus_wr(6'h08, 16'h0000);
    idle_chk("R11 bad unlock aborts");
    unlock(8'h00); bus_wr(6'h00, 16'h00F0); bus_wr(UA, 16'h00A0); bus_wr(6'h08, 16'h0000);
    idle_chk("R11 F0 cancels");
    rd_exp(6'h08, 1'b0, 16'hFFFF, 16'hFFFF, "R11 word kept");

    // lockout
    lockout = 1'b1;
    unlock(8'h00); bus_wr(UA, 16'h00A0); bus_wr(6'h09, 16'h0000);
    idle_chk("R6 locked program no busy");
    lockout = 1'b0;
    rd_exp(6'h09, 1'b0, 16'hFFFF, 16'hFFFF, "R6 locked word kept");
    unlock(8'h00);
    @(negedge clk); lockout = 1'b1; @(negedge clk); @(negedge clk); lockout = 1'b0;
    bus_wr(UA, 16'h00A0); bus_wr(6'h09, 16'h0000);
    idle_chk("R6 lockout drops sequence");
    rd_exp(6'h09, 1'b0, 16'hFFFF, 16'hFFFF, "R6 word kept after drop");

    // suspend and resume
    unlock(8'h00); bus_wr(UA, 16'h00A0); bus_wr(6'h30, 16'h5555);
    busy_len(n);
    erase_seq(6'h30, 8'h30);
    repeat (10) @(negedge clk);
    bus_wr(6'h00, 16'h00B0);
    @(negedge clk); chk("R4 ready on suspend", {31'b0, ready}, 32'd1);
    idle_chk("R4 ready held in suspend");
    rd_exp(6'h07, 1'b0, 16'hFFFF, 16'hFFFF, "R4 read during suspend");
    bus_wr(6'h00, 16'h0030);
    @(negedge clk); chk("R4 resume busy", {31'b0, ready}, 32'd0);
    busy_len(n);
    rd_exp(6'h30, 1'b0, 16'hFFFF, 16'hFFFF, "R2 erase done after resume");

    // erase interrupted by lockout
    erase_seq(6'h20, 8'h30);
    repeat (5) @(negedge clk);
    lockout = 1'b1;
    @(negedge clk);
    chk("R6 lockout ends busy", {31'b0, ready}, 32'd1);
    chk("R10 lockout marks sector", {28'b0, sector_bad}, 32'h4);
    lockout = 1'b0;
    erase_seq(6'h20, 8'h30);
    busy_len(n);
    chk("R10 re-erase clears flag", {28'b0, sector_bad}, 32'h0);

    // erase interrupted by reset
    erase_seq(6'h10, 8'h30);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); chk("R3 busy during reset", {31'b0, ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk); chk("R3 ready after reset", {31'b0, ready}, 32'd1);
    chk("R10 reset marks sector", {28'b0, sector_bad}, 32'h2);
    erase_seq(6'h10, 8'h30);
    busy_len(n);
    chk("R10 flag cleared again", {28'b0, sector_bad}, 32'h0);

    // byte mode
    word_mode = 1'b0;
    unlock(8'h00); bus_wr(UA, 16'h00A0); bus_wr(6'h0A, 16'h803C);
    busy_len(n); chk("R9 byte program busy", n, PCYC);
    rd_exp(6'h0A, 1'b1, 16'h003C, 16'h00FF, "R9 upper lane");
    rd_exp(6'h0A, 1'b0, 16'h00FF, 16'h00FF, "R9 lower lane untouched");
    word_mode = 1'b1;
    rd_exp(6'h0A, 1'b0, 16'h3CFF, 16'hFFFF, "R9 word view");
    @(negedge clk); chk("R13 no drive when idle", {16'b0, dq_oe}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule